// File: doc/BRIEF.md
# Time-Division Network Serial Transmitter

This block sends words onto a shared serial line that is divided into repeating frames of word-length time slots. Several devices take turns on the line, so in any slot the block either drives a word or releases the line (output enable low) so that another device can use it. Bit and frame timing come from outside as a serial clock and a word-length frame sync. Both are sampled by the system clock, and a rising edge of the serial clock is the bit event.

Software decides each slot one slot in advance. A data-empty flag rises at the start of every slot. Within that slot, software either writes the data register, which sends that word in the next slot, or writes the slot-disable register, which keeps the line released for the next slot. If software writes neither, an underrun is recorded and the previous word is sent again. A transmit enable input can stop the block: the word in flight always completes before the line is released.

Top module: `tdm_net_tx`

## Requirements
- R1: After reset, sd_oe, sd_o, tde, irq and underrun are 0 and slot_idx is 0.
- R2: A slot boundary falls on the serial-clock rising edge that follows WORD bits of the current slot, or on a rising edge where fsync is sampled high after being sampled low. At a frame-sync boundary slot_idx becomes 0. At any other boundary slot_idx advances by one and wraps from SLOTS-1 to 0. slot_idx does not change between boundaries.
- R3: tde is set at every slot boundary. irq equals tde AND irq_en.
- R4: A write with wr_addr 0 (data) or wr_addr 1 (slot disable) clears tde on the next clock. This applies even when the write falls on a boundary.
- R5: If a slot-disable write occurred during a slot, sd_oe is 0 for the whole of the next slot. This overrides a data write made in the same slot.
- R6: With tx_en high and no slot-disable write, the data register is copied at the boundary and sent MSB first. The output carries one bit per serial-clock rising edge: the first bit appears at the boundary, and sd_oe stays 1 for the whole slot.
- R7: If neither register was written during a slot and tx_en is high at the boundary, underrun is set and the previous data word is sent again with sd_oe 1.
- R8: underrun stays set until a write with wr_addr 2 and wr_data bit 0 equal to 1. Such a write with bit 0 equal to 0 leaves it unchanged.
- R9: tx_en is sampled only at boundaries. If it is dropped mid-slot, the current word completes. Every slot that begins while tx_en is low has sd_oe 0 and sets no underrun. Raising tx_en again resumes at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sclk | input | 1 | serial bit clock, sampled by clk |
| fsync | input | 1 | word-length frame sync, sampled on serial-clock rising edges |
| tx_en | input | 1 | transmit enable |
| irq_en | input | 1 | transmit interrupt enable |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | 0 data, 1 slot disable, 2 status clear |
| wr_data | input | WORD | write data |
| sd_o | output | 1 | serial data (0 when not driven) |
| sd_oe | output | 1 | serial data output enable |
| tde | output | 1 | data-empty flag |
| irq | output | 1 | transmit interrupt request |
| underrun | output | 1 | sticky underrun status |
| slot_idx | output | $clog2(SLOTS) | slot currently on the line |

## Verification
Every result is registered one system-clock edge after its cause. Slot, output enable, data bit, tde and underrun change on the edge where a serial-clock rise is seen. A register write changes tde, underrun or the data register on the edge that samples the strobe. The bench updates its reference model on that same edge from the inputs it drove at the previous falling edge. It compares at the following falling edge, so each expected value sits exactly one edge behind its stimulus. Directed checks are read at falling edges chosen after a whole slot has passed, or after the clear write.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_DIS  = 2'd1,
      REG_STAT = 2'd2
   } tx_reg_e;
endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
   parameter int WORD  = 16,
   parameter int SLOTS = 5,
   localparam int BW   = $clog2(WORD),
   localparam int SW   = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk,
   input  logic          fsync,
   output logic          tick,
   output logic          boundary,
   output logic [SW-1:0] slot_idx
);
   logic          sclk_q;
   logic          fs_q;
   logic [BW-1:0] bit_cnt;
   logic          fstart;
   logic          last_bit;

   always_comb begin
      tick     = sclk & ~sclk_q;
      fstart   = tick & fsync & ~fs_q;
      last_bit = (bit_cnt == BW'(WORD - 1));
      boundary = tick & (fstart | last_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         fs_q     <= 1'b0;
         bit_cnt  <= '0;
         slot_idx <= '0;
      end else begin
         sclk_q <= sclk;
         if (tick) fs_q <= fsync;
         if (boundary)  bit_cnt <= '0;
         else if (tick) bit_cnt <= bit_cnt + 1'b1;
         if (fstart)
            slot_idx <= '0;
         else if (boundary)
            slot_idx <= (slot_idx == SW'(SLOTS - 1)) ? '0 : slot_idx + 1'b1;
      end
   end
endmodule

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
   import tdm_tx_pkg::*;
#(
   parameter int WORD = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boundary,
   input  logic            tx_en,
   input  logic            irq_en,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [WORD-1:0] wr_data,
   output logic [WORD-1:0] data_q,
   output logic            load_act,
   output logic            dis_pend,
   output logic            tde,
   output logic            irq,
   output logic            underrun
);
   logic dat_pend;
   logic wr_dat, wr_dis, wr_clr, urun_set;

   always_comb begin
      wr_dat   = wr_en && (tx_reg_e'(wr_addr) == REG_DATA);
      wr_dis   = wr_en && (tx_reg_e'(wr_addr) == REG_DIS);
      wr_clr   = wr_en && (tx_reg_e'(wr_addr) == REG_STAT) && wr_data[0];
      load_act = tx_en && !dis_pend;
      urun_set = boundary && load_act && !dat_pend;
      irq      = tde & irq_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         dat_pend <= 1'b0;
         dis_pend <= 1'b0;
         tde      <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (wr_dat) data_q <= wr_data;
         if (boundary) begin
            dat_pend <= wr_dat;
            dis_pend <= wr_dis;
         end else begin
            dat_pend <= dat_pend | wr_dat;
            dis_pend <= dis_pend | wr_dis;
         end
         if (wr_dat || wr_dis) tde <= 1'b0;
         else if (boundary)    tde <= 1'b1;
         if (urun_set)    underrun <= 1'b1;
         else if (wr_clr) underrun <= 1'b0;
      end
   end
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
   parameter int WORD      = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            boundary,
   input  logic            load_act,
   input  logic [WORD-1:0] load_word,
   output logic            sd_o,
   output logic            sd_oe
);
   logic [WORD-1:0] sh;
   logic [WORD-1:0] sh_next;
   logic            out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh[WORD-2:0], 1'b0};
         assign out_bit = sh[WORD-1];
      end else begin : g_lsb
         assign sh_next = {1'b0, sh[WORD-1:1]};
         assign out_bit = sh[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         sd_oe <= 1'b0;
      end else if (boundary) begin
         sd_oe <= load_act;
         if (load_act) sh <= load_word;
      end else if (tick) begin
         sh <= sh_next;
      end
   end

   assign sd_o = sd_oe & out_bit;
endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx #(
   parameter int WORD      = 16,
   parameter int SLOTS     = 5,
   parameter bit MSB_FIRST = 1'b1,
   localparam int SW       = $clog2(SLOTS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk,
   input  logic            fsync,
   input  logic            tx_en,
   input  logic            irq_en,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [WORD-1:0] wr_data,
   output logic            sd_o,
   output logic            sd_oe,
   output logic            tde,
   output logic            irq,
   output logic            underrun,
   output logic [SW-1:0]   slot_idx
);
   generate
      if (WORD < 2)  begin : g_bad_word  $error("WORD must be at least 2");  end
      if (SLOTS < 2) begin : g_bad_slots $error("SLOTS must be at least 2"); end
   endgenerate

   logic            tick;
   logic            boundary;
   logic            load_act;
   logic            dis_pend;
   logic [WORD-1:0] data_q;

   tdm_tx_timing #(.WORD(WORD), .SLOTS(SLOTS)) u_timing (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync),
      .tick(tick), .boundary(boundary), .slot_idx(slot_idx)
   );

   tdm_tx_ctrl #(.WORD(WORD)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .tx_en(tx_en),
      .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .data_q(data_q), .load_act(load_act), .dis_pend(dis_pend),
      .tde(tde), .irq(irq), .underrun(underrun)
   );

   tdm_tx_shift #(.WORD(WORD), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .boundary(boundary),
      .load_act(load_act), .load_word(data_q), .sd_o(sd_o), .sd_oe(sd_oe)
   );
endmodule

// File: rtl/tdm_net_tx_chk.sv
module tdm_net_tx_chk #(
   parameter int WORD  = 16,
   parameter int SLOTS = 5,
   localparam int SW   = $clog2(SLOTS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            boundary,
   input logic            dis_pend,
   input logic            tx_en,
   input logic            wr_en,
   input logic [1:0]      wr_addr,
   input logic [WORD-1:0] wr_data,
   input logic            tde,
   input logic            underrun,
   input logic            sd_oe,
   input logic [SW-1:0]   slot_idx
);
   AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_idx <= SW'(SLOTS - 1)); // R2
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(slot_idx)); // R2
   AST_TDE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tde) |-> $past(boundary)); // R3
   AST_TDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1)) |=> !tde); // R4
   AST_DIS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && dis_pend) |=> !sd_oe); // R5
   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(sd_oe)); // R6
   AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> underrun); // R8
   AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !tx_en) |=> !sd_oe); // R9
endmodule

bind tdm_net_tx tdm_net_tx_chk #(.WORD(WORD), .SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .boundary(boundary), .dis_pend(dis_pend),
   .tx_en(tx_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .tde(tde), .underrun(underrun), .sd_oe(sd_oe), .slot_idx(slot_idx)
);

// File: tb/tdm_net_tx_tb.sv
module tdm_net_tx_tb_top;
   localparam int WORD  = 16;
   localparam int SLOTS = 5;
   localparam int SW    = $clog2(SLOTS);

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, fsync = 1'b0, tx_en = 1'b0, irq_en = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [WORD-1:0] wr_data = '0;
   logic sd_o, sd_oe, tde, irq, underrun;
   logic [SW-1:0] slot_idx;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk; // 125 MHz

   tdm_net_tx #(.WORD(WORD), .SLOTS(SLOTS)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .tx_en(tx_en),
      .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sd_o(sd_o), .sd_oe(sd_oe), .tde(tde), .irq(irq),
      .underrun(underrun), .slot_idx(slot_idx)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // serial clock: 4 system clocks per bit; frame sync high for first word of 80 bits
   int ph = 0, bitn = 0;
   always @(negedge clk) if (rst_n) begin
      ph = (ph + 1) % 4;
      if (ph == 0) bitn++;
      sclk  <= (ph >= 2);
      fsync <= ((bitn % (WORD * SLOTS)) < WORD);
   end

   // reference model
   int m_sq, m_fq, m_bit, m_slot, m_wd, m_wt, m_tde, m_ur, m_oe, m_pos;
   int unsigned m_data, m_word;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sq = 0; m_fq = 0; m_bit = 0; m_slot = 0; m_wd = 0; m_wt = 0;
         m_tde = 0; m_ur = 0; m_oe = 0; m_pos = 0; m_data = 0; m_word = 0;
      end else begin
         int tk, fs, bnd, wd, wt, wc;
         tk  = sclk && !m_sq;
         fs  = tk && fsync && !m_fq;
         bnd = tk && (fs || m_bit == WORD - 1);
         wd  = wr_en && wr_addr == 0;
         wt  = wr_en && wr_addr == 1;
         wc  = wr_en && wr_addr == 2 && wr_data[0];
         if (bnd) begin
            if (tx_en && !m_wt) begin
               if (!m_wd) m_ur = 1;
               m_oe = 1; m_word = m_data; m_pos = 0;
            end else m_oe = 0;
            m_wd = wd; m_wt = wt;
            m_slot = fs ? 0 : (m_slot + 1) % SLOTS;
            m_bit = 0;
         end else begin
            if (wc) m_ur = 0;
            if (wd) m_wd = 1;
            if (wt) m_wt = 1;
            if (tk) begin m_bit++; m_pos++; end
         end
         if (wd || wt) m_tde = 0; else if (bnd) m_tde = 1;
         if (wd) m_data = wr_data;
         if (tk) m_fq = fsync;
         m_sq = sclk;
      end
   end

   always @(negedge clk) if (rst_n && !done) begin
      chk(slot_idx == m_slot, "R2 slot_idx", slot_idx, m_slot);
      chk(tde == m_tde, "R3/R4 tde", tde, m_tde);
      chk(irq == (m_tde && irq_en), "R3 irq", irq, m_tde && irq_en);
      chk(underrun == m_ur, "R7 underrun", underrun, m_ur);
      chk(sd_oe == m_oe, "R5/R6 sd_oe", sd_oe, m_oe);
      if (m_oe) chk(sd_o == m_word[WORD-1-m_pos], "R6 sd_o", sd_o, m_word[WORD-1-m_pos]);
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); wr_en = 1; wr_addr = 2'(a); wr_data = WORD'(d);
      @(negedge clk); wr_en = 0;
   endtask

   task automatic next_slot();
      int s;
      @(negedge clk); s = slot_idx;
      while (slot_idx == s) @(negedge clk);
   endtask

   // policy 0: send in slots 0 and 3; 1: idle; 2: both writes; 3: data always
   task automatic serve(input int n, input int pol);
      for (int i = 0; i < n; i++) begin
         int nx;
         next_slot();
         nx = (slot_idx + 1) % SLOTS;
         case (pol)
            0: if (nx == 0 || nx == 3) wr(0, 16'hA500 + nx); else wr(1, 0);
            2: begin wr(0, 16'h1234); wr(1, 0); end
            3: wr(0, 16'hC3C0 + i);
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sd_oe == 0 && sd_o == 0, "R1 output", sd_oe, 0);
      chk(tde == 0 && irq == 0, "R1 tde", tde, 0);
      chk(underrun == 0, "R1 underrun", underrun, 0);
      chk(slot_idx == 0, "R1 slot", slot_idx, 0);
      rst_n = 1;
      wr(0, 16'h8001);
      tx_en = 1; irq_en = 1;
      serve(12, 0);          // R5 R6 pattern frame
      irq_en = 0;
      serve(3, 3);
      serve(2, 1);           // R7 underrun with repeat
      next_slot();
      chk(underrun == 1, "R7 set after idle slot", underrun, 1);
      wr(0, 16'h5A5A);
      wr(2, 0);
      chk(underrun == 1, "R8 clear with bit0=0 ignored", underrun, 1);
      wr(2, 1);
      chk(underrun == 0, "R8 cleared by bit0=1", underrun, 0);
      serve(3, 2);           // R5 disable overrides data
      serve(2, 3);
      repeat (20) @(negedge clk);
      tx_en = 0;             // R9 mid-word
      @(negedge clk);
      chk(sd_oe == 1, "R9 word in flight keeps driving", sd_oe, 1);
      serve(3, 1);
      chk(sd_oe == 0, "R9 released while disabled", sd_oe, 0);
      chk(underrun == 0, "R9 no underrun while disabled", underrun, 0);
      tx_en = 1;
      serve(4, 3);
      chk(sd_oe == 1, "R9 resumed", sd_oe, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule